// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block derives a UART bit-rate tick from the system clock with a two-stage divider. An integer prescaler first cuts the clock down by (scale + 1). Each prescaled pulse then adds a 16-bit step into a 17-bit phase accumulator. Every wrap of that accumulator raises the tick output for one cycle. The tick rate is therefore clk / (scale + 1) × step / 2^17. This gives fractional rates far finer than a plain divide-by-N counter can reach.

Software programs the rate by writing one 32-bit word to the clock register through a simple write port. Any write that hits the register restarts the prescaler and the accumulator from zero. The new rate then starts with a whole period, never a leftover fragment of the old one. The downstream UART takes `baud_tick` as its bit or oversample enable.

Top module: `frac_baud_gen`

## Requirements
- R1: Over a window of N cycles after programming, the number of tick cycles is within one of N × step / ((scale + 1) × 2^17).
- R2: A write is decoded as follows: scale is taken from bits [27:16] (12 bits), step from bits [15:0] (16 bits), and bits [31:28] are ignored.
- R3: The prescaler counts 0..scale and pulses once every scale + 1 cycles; with scale 0 it pulses on every clock.
- R4: Each prescaler pulse adds step into a 17-bit accumulator. The carry out of bit 16 sets `baud_tick` in the cycle after that pulse. With scale 2 and step 0x8000, counting the first cycle after the write as cycle 0, ticks appear in cycles 12 and 24 only.
- R5: A write to the clock register clears the prescaler, the accumulator and `baud_tick` at the same edge, so timing restarts from that write.
- R6: A step of 0 produces no ticks at all.
- R7: After reset, scale and step are 0 and `baud_tick` is low and stays low until a rate is programmed.
- R8: With scale above 0, `baud_tick` is never high in two consecutive cycles.
- R9: The clock register is at offset 0x08 only; a write to any other offset leaves the configuration and the running phase unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe, one cycle per write |
| cfg_addr | input | 8 | Register byte offset of the write |
| cfg_wdata | input | 32 | Write data: scale in [27:16], step in [15:0] |
| baud_tick | output | 1 | One-cycle pulse at each accumulator wrap |

## Verification
The assertions assume that the write port is only sampled on the clock edge. They also assume that a write strobe lasts exactly one cycle, since any hit of the clock register is treated as a restart. The stimulus drives every input on the falling edge and holds each write for a single cycle. The property that ticks never come back to back under a nonzero scale relies on step being narrower than the accumulator. The port width guarantees this for every value the bench writes, including the all-ones step.

// File: rtl/baud_pkg.sv
// Package: baud_pkg
// Shared widths, field positions and the configuration type for the
// fractional baud tick generator. Assumes a 32-bit clock register.
package baud_pkg;

    localparam int CFG_ADDR_W    = 8;
    localparam int CFG_DATA_W    = 32;
    localparam logic [CFG_ADDR_W-1:0] CLK_REG_OFFSET = 8'h08;

    localparam int SCALE_W   = 12;
    localparam int SCALE_LSB = 16;
    localparam int STEP_W    = 16;
    localparam int STEP_LSB  = 0;
    localparam int ACC_W     = STEP_W + 1;

    typedef struct packed {
        logic [SCALE_W-1:0] scale;
        logic [STEP_W-1:0]  step;
    } baud_cfg_t;

endpackage

// File: rtl/baud_cfg_reg.sv
// Module: baud_cfg_reg
// Holds the programmed scale and step. It decodes writes to the clock
// register offset and flags each hit as a restart for the counters.
// Assumes: cfg_we is a single-cycle strobe; unused data bits are dropped.
module baud_cfg_reg
    import baud_pkg::*;
#(
    parameter int ADDR_W    = CFG_ADDR_W,
    parameter int DATA_W    = CFG_DATA_W,
    parameter int SCL_W     = SCALE_W,
    parameter int SCL_LSB   = SCALE_LSB,
    parameter int STP_W     = STEP_W,
    parameter int STP_LSB   = STEP_LSB,
    parameter logic [ADDR_W-1:0] REG_OFFSET = CLK_REG_OFFSET
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [SCL_W-1:0]  scale,
    output logic [STP_W-1:0]  step,
    output logic              restart
);

    localparam int SCL_MSB = SCL_LSB + SCL_W - 1;
    localparam int STP_MSB = STP_LSB + STP_W - 1;

    logic [SCL_W-1:0] scale_d;
    logic [STP_W-1:0] step_d;
    logic             top_bits_unused;

    // Address decode: only the clock register offset counts as a hit.
    always_comb begin
        restart = we && (addr == REG_OFFSET);
    end

    // Field extraction from the write word.
    always_comb begin
        scale_d = wdata[SCL_MSB:SCL_LSB];
        step_d  = wdata[STP_MSB:STP_LSB];
    end

    // Bits above the scale field carry no meaning.
    assign top_bits_unused = ^wdata[DATA_W-1:SCL_MSB+1];

    // Configuration storage, loaded on a register hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scale <= '0;
            step  <= '0;
        end else if (restart) begin
            scale <= scale_d;
            step  <= step_d;
        end
    end

    // R2
    scale_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (scale == $past(wdata[SCL_MSB:SCL_LSB])));

    // R2
    step_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (step == $past(wdata[STP_MSB:STP_LSB])));

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> ($stable(scale) && $stable(step)));

endmodule

// File: rtl/baud_prescaler.sv
// Module: baud_prescaler
// Integer prescaler. It counts 0..scale and pulses on the last count,
// one pulse every scale+1 cycles (every cycle when scale is 0).
// Assumes: clr comes in the same cycle as the new scale value is written.
module baud_prescaler
    import baud_pkg::*;
#(
    parameter int CNT_W = SCALE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] scale,
    output logic             pulse
);

    logic [CNT_W-1:0] cnt;

    // Terminal count detect.
    always_comb begin
        pulse = (cnt == scale);
    end

    // Count register with restart and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || pulse) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= scale);

    // R5
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    // R3
    cnt_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !pulse) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/baud_phase_acc.sv
// Module: baud_phase_acc
// Phase accumulator. It adds step on every prescaler pulse and registers
// the carry out of its top bit as a single-cycle tick.
// Assumes: step is one bit narrower than the accumulator.
module baud_phase_acc
    import baud_pkg::*;
#(
    parameter int STP_W = STEP_W,
    parameter int ACC_BITS = STP_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             pulse,
    input  logic [STP_W-1:0] step,
    output logic             tick
);

    localparam int SUM_W = ACC_BITS + 1;

    logic [ACC_BITS-1:0] acc;
    logic [SUM_W-1:0]    sum;

    // Next phase, with the carry in the top bit.
    always_comb begin
        sum = {1'b0, acc} + {{(SUM_W-STP_W){1'b0}}, step};
    end

    // Phase register and tick flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= '0;
            tick <= 1'b0;
        end else if (clr) begin
            acc  <= '0;
            tick <= 1'b0;
        end else if (pulse) begin
            acc  <= sum[ACC_BITS-1:0];
            tick <= sum[SUM_W-1];
        end else begin
            tick <= 1'b0;
        end
    end

    // R4
    tick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(pulse));

    // R5
    acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc == '0 && !tick));

    // R6
    zero_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && step == '0) |=> (!tick && acc == $past(acc)));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !pulse) |=> $stable(acc));

endmodule

// File: rtl/frac_baud_gen.sv
// Module: frac_baud_gen
// Top of the fractional baud tick generator. It chains the configuration
// register, the integer prescaler and the phase accumulator. Tick rate is
// clk / (scale+1) * step / 2^17.
// Assumes: synchronous active-low reset; single-cycle write strobes.
module frac_baud_gen
    import baud_pkg::*;
#(
    parameter int ADDR_W = CFG_ADDR_W,
    parameter int DATA_W = CFG_DATA_W,
    parameter int SCL_W  = SCALE_W,
    parameter int STP_W  = STEP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              baud_tick
);

    baud_cfg_t cfg;
    logic      restart;
    logic      pre_pulse;

    baud_cfg_reg #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .SCL_W   (SCL_W),
        .STP_W   (STP_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .scale   (cfg.scale),
        .step    (cfg.step),
        .restart (restart)
    );

    baud_prescaler #(
        .CNT_W (SCL_W)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart),
        .scale (cfg.scale),
        .pulse (pre_pulse)
    );

    baud_phase_acc #(
        .STP_W (STP_W)
    ) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart),
        .pulse (pre_pulse),
        .step  (cfg.step),
        .tick  (baud_tick)
    );

    // R8
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.scale != '0 && baud_tick) |=> !baud_tick);

    // R5
    restart_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !baud_tick);

endmodule

// File: tb/frac_baud_gen_tb.sv
module frac_baud_gen_tb;

    localparam int NVEC   = 8;
    localparam int WINDOW = 8192;
    localparam logic [7:0] REG_OFS = 8'h08;

    // cfg word, expected tick count over WINDOW (floor of formula)
    localparam logic [31:0] VEC_CFG [NVEC] = '{
        32'h0000_FFFF, 32'h0000_8000, 32'h0003_1234, 32'h0001_03E8,
        32'h0009_FFFF, 32'h0000_0001, 32'hF000_4000, 32'h0FFF_FFFF
    };
    localparam int VEC_EXP [NVEC] = '{4095, 2048, 72, 31, 409, 0, 1024, 0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        baud_tick;

    int checks = 0;
    int errors = 0;
    logic hist [0:31];

    always #4 clk = ~clk;

    frac_baud_gen u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .baud_tick (baud_tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge of cycle 0.
    task automatic write_reg(input logic [7:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    endtask

    task automatic count_ticks(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            if (baud_tick) c++;
            @(negedge clk);
        end
    endtask

    task automatic capture(input int from, input int upto);
        for (int k = from; k <= upto; k++) begin
            hist[k] = baud_tick;
            @(negedge clk);
        end
    endtask

    function automatic int hist_count(input int from, input int upto);
        int c = 0;
        for (int k = from; k <= upto; k++) if (hist[k]) c++;
        return c;
    endfunction

    initial begin
        int c, d;
        for (int k = 0; k < 32; k++) hist[k] = 1'b0;
        repeat (5) @(negedge clk);
        check(baud_tick == 1'b0, "R7 reset", int'(baud_tick), 0);
        rst_n = 1'b1;
        count_ticks(200, c);
        check(c == 0, "R7 idle after reset", c, 0);

        // Table walk: rate per formula, field decode, prescaler at scale 0
        for (int v = 0; v < NVEC; v++) begin
            write_reg(REG_OFS, VEC_CFG[v]);
            count_ticks(WINDOW, c);
            d = c - VEC_EXP[v];
            check(d >= -1 && d <= 1, $sformatf("R1/R2/R3 vec%0d", v), c, VEC_EXP[v]);
        end

        // R4: exact tick timing, scale 2 step 0x8000
        write_reg(REG_OFS, 32'h0002_8000);
        capture(0, 25);
        check(hist[12] == 1'b1, "R4 first tick cycle 12", int'(hist[12]), 1);
        check(hist[24] == 1'b1, "R4 second tick cycle 24", int'(hist[24]), 1);
        check(hist_count(0, 25) == 2, "R4 tick count 0..25", hist_count(0, 25), 2);
        check(hist[13] == 1'b0, "R8 no back-to-back tick", int'(hist[13]), 0);

        // R5: rewrite mid-period restarts the phase
        write_reg(REG_OFS, 32'h0002_8000);
        capture(0, 10);
        check(hist_count(0, 10) == 0, "R5 no tick before rewrite", hist_count(0, 10), 0);
        write_reg(REG_OFS, 32'h0002_8000);
        capture(0, 12);
        check(hist_count(0, 11) == 0, "R5 no tick 0..11 after rewrite", hist_count(0, 11), 0);
        check(hist[12] == 1'b1, "R5 tick at 12 after rewrite", int'(hist[12]), 1);

        // R9: write to another offset leaves phase and rate alone
        write_reg(REG_OFS, 32'h0002_8000);
        capture(0, 5);
        write_reg(8'h04, 32'h0000_FFFF);
        capture(7, 25);
        check(hist_count(7, 11) == 0, "R9 no early tick after stray write", hist_count(7, 11), 0);
        check(hist[12] == 1'b1, "R9 tick still at 12", int'(hist[12]), 1);
        check(hist[24] == 1'b1, "R9 tick still at 24", int'(hist[24]), 1);

        // R5/R6: fast rate, then step 0 clears tick and stops ticks
        write_reg(REG_OFS, 32'h0000_FFFF);
        repeat (7) @(negedge clk);
        write_reg(REG_OFS, 32'h0000_0000);
        check(baud_tick == 1'b0, "R5 tick cleared by write", int'(baud_tick), 0);
        count_ticks(2000, c);
        check(c == 0, "R6 step zero no ticks", c, 0);

        // R6 with a large scale as well
        write_reg(REG_OFS, 32'h0005_0000);
        count_ticks(500, c);
        check(c == 0, "R6 step zero scale 5", c, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule